// File: doc/BRIEF.md
# Fixed-Priority DMA Request Arbiter

This block sits on the host side of a DMA request handshake for seven channels. Channels 0 to 3 move bytes and channels 5 to 7 move words. Slot 4 of every vector exists, but it has no channel behind it. Each request line arrives asynchronously and is active high. The block resynchronizes each line and picks the lowest-numbered eligible channel. It answers with an active-low acknowledge, which the card uses as the select for its data register.

A grant stays with its channel until the transfer finishes. For a normal channel, a per-channel length value sets how long the transfer lasts. The terminal-count line is modelled as three separate signals: an output, an output enable and an input. A channel in output mode drives the terminal-count line on its last cycle. A channel in input mode lets the slave pulse the same line to cut the transfer short.

A channel in cascade mode only hands over the bus. It then holds the grant for as long as the card keeps its request high. Word channels need an even, full-width address: address bit 0 low and the active-low high-byte enable low. A misaligned word request is refused and flagged.

Top module: `dma_req_arbiter`

## Requirements
- R1: A request raised between two rising edges shows on its acknowledge after the third rising edge that follows. Two of those edges are synchronizer stages and one is the grant register. The acknowledge stays high after the second edge.
- R2: In the idle state the eligible channel with the lowest index is granted. Bit i of dreq_async and dack_n belongs to channel i.
- R3: At most one bit of dack_n is low at any time. The acknowledge is low for exactly the granted channel.
- R4: A grant is never moved to another channel while it runs, even if a higher-priority request arrives. The block returns to idle for at least one cycle before it grants again.
- R5: Bit 4 of dreq_async is ignored, and dack_n[4] always stays 1.
- R6: In output mode (tc_in_mode bit 0) a normal grant keeps its acknowledge low for xfer_len+1 cycles, where xfer_len is sampled at the grant. tc_oe is 1 for the whole grant. tc_out is 1 only on the final cycle.
- R7: In input mode (tc_in_mode bit 1) tc_oe and tc_out stay 0. If tc_in is 1 at a rising edge, the grant ends at that edge. In output mode tc_in has no effect.
- R8: Channels 5 to 7 are eligible only when addr0 is 0 and hbe_n is 0. Channels 0 to 3 are eligible whatever the address.
- R9: align_err is 1 in the cycle after an idle cycle in which a synchronized request on channel 5 to 7 was present while addr0 or hbe_n was 1. Otherwise align_err is 0.
- R10: In cascade mode (cascade_mode bit 1) the grant ignores xfer_len and never drives the terminal-count line. The grant ends at the third rising edge after the request falls.
- R11: While rst is high, all of dack_n is 1 and tc_out, tc_oe and align_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq_async | input | 8 | Asynchronous request lines, one per channel slot |
| cascade_mode | input | 8 | Per-channel cascade selection |
| tc_in_mode | input | 8 | Per-channel terminal-count direction, 1 = input |
| xfer_len | input | CNT_W | Transfer length, loaded at grant |
| addr0 | input | 1 | Address bit 0 of the word request |
| hbe_n | input | 1 | High-byte enable, active low |
| tc_in | input | 1 | Terminal-count line as driven by the slave |
| dack_n | output | 8 | Active-low acknowledges |
| tc_out | output | 1 | Terminal-count value driven by the host |
| tc_oe | output | 1 | Terminal-count drive enable |
| align_err | output | 1 | Misaligned word request seen |

## Verification
Two events can fall in the same cycle.

The first pair is a priority decision and an alignment refusal. The bench raises a misaligned word request together with a byte request. In the sampled cycle it expects the byte channel to be granted and align_err to be 1 at once.

The second pair is a running grant and a newly arriving higher-priority request. The bench drops channel 3's request and raises channel 0's while channel 3 is granted. It expects channel 3 to keep the bus until its count ends, and only then channel 0 to be acknowledged.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int NCH   = 8;
    localparam int IDX_W = $clog2(NCH);
    localparam logic [NCH-1:0] WORD_MASK  = 8'hE0;
    localparam logic [NCH-1:0] CH_PRESENT = 8'hEF;

    typedef logic [IDX_W-1:0] ch_idx_t;

    typedef struct packed {
        logic    busy;
        ch_idx_t ch;
    } grant_t;

    function automatic ch_idx_t first_set(input logic [NCH-1:0] v);
        ch_idx_t r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) r = ch_idx_t'(i);
        end
        return r;
    endfunction

    function automatic logic word_aligned(input logic a0, input logic hbe_n);
        return !a0 && !hbe_n;
    endfunction
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_async[i];
                s2 <= s1;
            end
        end
        assign q_sync[i] = s2;
    end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
    import dma_arb_pkg::*;
(
    input  logic [NCH-1:0] req_s,
    input  logic           addr0,
    input  logic           hbe_n,
    output logic           any,
    output ch_idx_t        idx,
    output logic           misaligned
);
    logic           ok;
    logic [NCH-1:0] eligible;

    always_comb begin
        ok         = word_aligned(addr0, hbe_n);
        eligible   = req_s & CH_PRESENT & (ok ? {NCH{1'b1}} : ~WORD_MASK);
        any        = |eligible;
        idx        = first_set(eligible);
        misaligned = !ok && |(req_s & WORD_MASK);
    end
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
    import dma_arb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pick_any,
    input  ch_idx_t          pick_idx,
    input  logic             misaligned,
    input  logic [NCH-1:0]   req_s,
    input  logic [NCH-1:0]   cascade_mode,
    input  logic [NCH-1:0]   tc_in_mode,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             tc_in,
    output logic [NCH-1:0]   dack_n,
    output logic             tc_out,
    output logic             tc_oe,
    output logic             align_err
);
    grant_t           g;
    logic [CNT_W-1:0] cnt;
    logic             casc, inm, end_now;

    always_comb begin
        casc    = cascade_mode[g.ch];
        inm     = tc_in_mode[g.ch];
        end_now = casc ? !req_s[g.ch] : ((cnt == '0) || (inm && tc_in));
        dack_n  = g.busy ? ~({{(NCH-1){1'b0}}, 1'b1} << g.ch) : {NCH{1'b1}};
        tc_oe   = g.busy && !casc && !inm;
        tc_out  = tc_oe && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g         <= '0;
            cnt       <= '0;
            align_err <= 1'b0;
        end else begin
            align_err <= !g.busy && misaligned;
            if (!g.busy) begin
                if (pick_any) begin
                    g.busy <= 1'b1;
                    g.ch   <= pick_idx;
                    cnt    <= xfer_len;
                end
            end else if (end_now) begin
                g.busy <= 1'b0;
            end else if (!casc) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   dreq_async,
    input  logic [NCH-1:0]   cascade_mode,
    input  logic [NCH-1:0]   tc_in_mode,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             addr0,
    input  logic             hbe_n,
    input  logic             tc_in,
    output logic [NCH-1:0]   dack_n,
    output logic             tc_out,
    output logic             tc_oe,
    output logic             align_err
);
    logic [NCH-1:0] req_s;
    logic           pick_any, misaligned;
    ch_idx_t        pick_idx;

    dma_req_sync #(.W(NCH)) u_sync (
        .clk(clk), .rst(rst), .d_async(dreq_async), .q_sync(req_s)
    );

    dma_prio_pick u_pick (
        .req_s(req_s), .addr0(addr0), .hbe_n(hbe_n),
        .any(pick_any), .idx(pick_idx), .misaligned(misaligned)
    );

    dma_xfer_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk(clk), .rst(rst), .pick_any(pick_any), .pick_idx(pick_idx),
        .misaligned(misaligned), .req_s(req_s), .cascade_mode(cascade_mode),
        .tc_in_mode(tc_in_mode), .xfer_len(xfer_len), .tc_in(tc_in),
        .dack_n(dack_n), .tc_out(tc_out), .tc_oe(tc_oe), .align_err(align_err)
    );
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk
    import dma_arb_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] dack_n,
    input logic [NCH-1:0] cascade_mode,
    input logic [NCH-1:0] tc_in_mode,
    input logic           addr0,
    input logic           hbe_n,
    input logic           tc_out,
    input logic           tc_oe
);
    a_r3_one_ack: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dack_n));

    a_r5_slot4_idle: assert property (@(posedge clk) disable iff (rst)
        dack_n[4]);

    a_r4_no_preempt: assert property (@(posedge clk) disable iff (rst)
        (dack_n != {NCH{1'b1}}) |=> (dack_n == $past(dack_n) || dack_n == {NCH{1'b1}}));

    a_r6_tc_needs_drive: assert property (@(posedge clk) disable iff (rst)
        tc_out |-> (tc_oe && dack_n != {NCH{1'b1}}));

    a_r7_input_mode_quiet: assert property (@(posedge clk) disable iff (rst)
        tc_oe |-> (((~dack_n) & tc_in_mode) == '0));

    a_r10_cascade_quiet: assert property (@(posedge clk) disable iff (rst)
        (((~dack_n) & cascade_mode) != '0) |-> !tc_oe);

    a_r8_word_aligned: assert property (@(posedge clk) disable iff (rst)
        ((((~dack_n) & WORD_MASK) != '0) && $past(dack_n) == {NCH{1'b1}})
        |-> $past(!addr0 && !hbe_n));
endmodule

bind dma_req_arbiter dma_req_arbiter_chk u_chk (
    .clk(clk), .rst(rst), .dack_n(dack_n), .cascade_mode(cascade_mode),
    .tc_in_mode(tc_in_mode), .addr0(addr0), .hbe_n(hbe_n),
    .tc_out(tc_out), .tc_oe(tc_oe)
);

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       dreq_async = '0;
    logic [7:0]       cascade_mode = '0;
    logic [7:0]       tc_in_mode = '0;
    logic [CNT_W-1:0] xfer_len = 8'd3;
    logic             addr0 = 1'b0;
    logic             hbe_n = 1'b0;
    logic             tc_in = 1'b0;
    logic [7:0]       dack_n;
    logic             tc_out, tc_oe, align_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_req_arbiter #(.CNT_W(CNT_W)) u_dma_req_arbiter (
        .clk(clk), .rst(rst), .dreq_async(dreq_async), .cascade_mode(cascade_mode),
        .tc_in_mode(tc_in_mode), .xfer_len(xfer_len), .addr0(addr0), .hbe_n(hbe_n),
        .tc_in(tc_in), .dack_n(dack_n), .tc_out(tc_out), .tc_oe(tc_oe),
        .align_err(align_err)
    );

    typedef struct packed {
        logic [7:0] req;
        logic       a0;
        logic       hb;
        logic [7:0] exp_dack;
        logic       exp_err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 1'b0, 1'b0, 8'hFE, 1'b0},
        '{8'h0E, 1'b0, 1'b0, 8'hFD, 1'b0},
        '{8'hE0, 1'b0, 1'b0, 8'hDF, 1'b0},
        '{8'hC0, 1'b0, 1'b0, 8'hBF, 1'b0},
        '{8'hE8, 1'b1, 1'b0, 8'hF7, 1'b1},
        '{8'hE0, 1'b0, 1'b1, 8'hFF, 1'b1},
        '{8'h10, 1'b0, 1'b0, 8'hFF, 1'b0},
        '{8'h90, 1'b0, 1'b0, 8'h7F, 1'b0},
        '{8'h60, 1'b1, 1'b1, 8'hFF, 1'b1}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int nlow, ntc, tc_at;
        bit oe_ok;
        step(3);
        // R11 reset state
        check("R11 dack_n in reset", dack_n, 8'hFF);
        check("R11 tc_oe in reset", tc_oe, 0);
        check("R11 tc_out in reset", tc_out, 0);
        check("R11 align_err in reset", align_err, 0);
        rst = 1'b0;
        step(2);

        // Vector table: priority, alignment, slot 4
        for (int v = 0; v < NV; v++) begin
            addr0 = VECS[v].a0;
            hbe_n = VECS[v].hb;
            dreq_async = VECS[v].req;
            step(2);
            check($sformatf("R1 no ack after two edges v%0d", v), dack_n, 8'hFF);
            step(1);
            check($sformatf("R2 R8 R5 grant v%0d", v), dack_n, VECS[v].exp_dack);
            check($sformatf("R9 align_err v%0d", v), align_err, VECS[v].exp_err);
            dreq_async = '0;
            step(10);
            check($sformatf("R4 back to idle v%0d", v), dack_n, 8'hFF);
        end
        addr0 = 1'b0;
        hbe_n = 1'b0;

        // R6 output-mode length and terminal count
        xfer_len = 8'd3;
        dreq_async = 8'h02;
        step(3);
        dreq_async = '0;
        nlow = 0; ntc = 0; tc_at = -1; oe_ok = 1;
        for (int i = 0; i < 10; i++) begin
            if (dack_n == 8'hFD) begin
                if (!tc_oe) oe_ok = 0;
                if (tc_out) begin ntc++; tc_at = nlow; end
                nlow++;
            end
            step(1);
        end
        check("R6 ack low cycles", nlow, 4);
        check("R6 tc_out pulses", ntc, 1);
        check("R6 tc_out on last cycle", tc_at, 3);
        check("R6 tc_oe through grant", oe_ok, 1);

        // R4 no preemption by higher priority
        dreq_async = 8'h08;
        step(3);
        check("R4 grant ch3", dack_n, 8'hF7);
        dreq_async = 8'h01;
        step(2);
        check("R4 ch3 kept while ch0 pending", dack_n, 8'hF7);
        step(3);
        check("R4 ch0 after ch3 finishes", dack_n, 8'hFE);
        dreq_async = '0;
        step(8);

        // R7 input-mode abort
        tc_in_mode = 8'h04;
        xfer_len = 8'd20;
        dreq_async = 8'h04;
        step(3);
        check("R7 input-mode grant", dack_n, 8'hFB);
        check("R7 no drive in input mode", tc_oe, 0);
        dreq_async = '0;
        step(2);
        check("R7 still granted before abort", dack_n, 8'hFB);
        tc_in = 1'b1;
        step(1);
        tc_in = 1'b0;
        check("R7 abort ends grant", dack_n, 8'hFF);
        step(4);

        // R7 output mode ignores tc_in
        tc_in_mode = '0;
        dreq_async = 8'h04;
        step(3);
        dreq_async = '0;
        tc_in = 1'b1;
        step(1);
        tc_in = 1'b0;
        check("R7 tc_in ignored in output mode", dack_n, 8'hFB);
        step(25);

        // R10 cascade
        cascade_mode = 8'h02;
        xfer_len = 8'd1;
        dreq_async = 8'h02;
        step(3);
        check("R10 cascade grant", dack_n, 8'hFD);
        check("R10 no tc drive", tc_oe, 0);
        step(8);
        check("R10 held past count", dack_n, 8'hFD);
        dreq_async = '0;
        step(2);
        check("R10 held two edges after drop", dack_n, 8'hFD);
        step(1);
        check("R10 released third edge", dack_n, 8'hFF);
        cascade_mode = '0;
        step(2);

        // R11 reset mid-grant
        xfer_len = 8'd20;
        dreq_async = 8'h01;
        step(3);
        rst = 1'b1;
        dreq_async = '0;
        step(1);
        check("R11 reset clears grant", dack_n, 8'hFF);
        rst = 1'b0;
        step(2);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule